// File: doc/BRIEF.md
# Four-Channel PWM Timer with Break Protection

This block drives four edge-aligned pulse-width outputs, each with an optional complementary pin, from one shared prescaler and one up-counter. Every channel compares the common count against its own threshold, so all channels run at the same period and differ only in duty. Software programs the block through a simple synchronous register port. The period value can be buffered so that a change lands cleanly at a period boundary. A write-triggered update event restarts the count and loads all buffered values at once.

Two break inputs protect the load. Each has its own enable, its own active level and a digital filter that needs a programmable run of consecutive active samples. A qualified break drives every pin, main and complementary, to its inactive level at once and clears the main output enable. The main output enable then stays clear until software sets it again, or, if automatic re-arm is selected, until the first update event after the break has gone away.

Top module: `pwmb_top`

## Requirements
- R1: After reset every register reads zero except the period register, which reads all ones. All pins are low and the counter is stopped.
- R2: While running, the counter advances once every (prescaler register + 1) clocks. It wraps to zero after reaching the active period value. Each wrap is an update event. Addresses: control 0, update 1, prescaler 2, period 3, count (read only) 10.
- R3: A channel is in its active phase while the count is below its compare value (addresses 5 to 8 for channels 0 to 3). A compare of zero never becomes active, and a compare above the period value stays active for the whole period.
- R4: Channel k owns bits 4k to 4k+3 of the channel register (address 4): output enable at +0, output polarity at +1, complementary enable at +2, complementary polarity at +3. A pin that is disabled, or gated off, sits at its polarity bit. The complementary pin is active in the main output's inactive phase.
- R5: Control bit 1 selects buffered reload. When set, a new period value takes effect only at the next update event. When clear, it takes effect at once.
- R6: Writing 1 to bit 0 of the update address sets counter and prescaler to zero in that clock. In the same clock it loads the prescaler, period and compare values.
- R7: Control bit 0 (run) can be set at any time. A write that clears it is ignored while any channel enable bit is set.
- R8: Break b uses byte b of the break register (address 9): enable at bit 0, active-high at bit 1, filter F at bits 5:2. It qualifies after F+1 consecutive active samples. A shorter active run has no effect, and a disabled break has no effect.
- R9: In the cycle a break qualifies, every main and complementary pin goes to its inactive level. The main output enable is cleared on the next clock, and writes that set it are ignored while any break stays qualified.
- R10: Control bit 3 is the main output enable and gates all pins. With control bit 2 (automatic re-arm) set, it is set again at the first update event with no break qualified. With bit 2 clear, it stays cleared until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| brkIn | input | 2 | Break inputs, synchronous to clk |
| pwmOut | output | 4 | Main PWM pins, one per channel |
| pwmOutN | output | 4 | Complementary PWM pins, one per channel |

## Verification
The assertions assume that the break inputs are already synchronous to the clock, and that no register write lands in the reset cycle. The stimulus changes the break pins only on falling clock edges, and issues writes one at a time between rising edges. The checks on counter stepping and run hold assume that the period is never lowered below the current count while buffering is off. The bench lowers the period only right after a software update, when the count is still near zero.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CH_CFG_W = 4;
  localparam int unsigned BRK_SLOT = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_UPDATE = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PERIOD = 4'd3;
  localparam logic [ADDR_W-1:0] A_CHCFG  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP0   = 4'd5;
  localparam logic [ADDR_W-1:0] A_BRKCFG = 4'd9;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd10;

  localparam int unsigned CTL_RUN = 0;
  localparam int unsigned CTL_PRE = 1;
  localparam int unsigned CTL_AOE = 2;
  localparam int unsigned CTL_MOE = 3;

  localparam int unsigned CFG_EN   = 0;
  localparam int unsigned CFG_POL  = 1;
  localparam int unsigned CFG_NEN  = 2;
  localparam int unsigned CFG_NPOL = 3;

  typedef struct packed {
    logic swUpdate;
    logic cntRun;
    logic arPreload;
    logic outGate;
  } dpCtrlT;
endpackage

// File: rtl/pwmb_brkfilt.sv
module pwmb_brkfilt #(
  parameter int unsigned FLT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             activeHigh,
  input  logic [FLT_W-1:0] filt,
  input  logic             rawIn,
  output logic             hit
);
  localparam int unsigned RUN_W = FLT_W + 1;

  logic [RUN_W-1:0] runLen;
  logic             lvlActive;

  assign lvlActive = (rawIn == activeHigh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
      hit    <= 1'b0;
    end else if (en && lvlActive) begin
      if (runLen <= RUN_W'(filt)) runLen <= runLen + RUN_W'(1);
      hit <= (runLen >= RUN_W'(filt));
    end else begin
      runLen <= '0;
      hit    <= 1'b0;
    end
  end

  AST_FILTER_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hit) |-> ($past(en) && $past(rawIn == activeHigh))); // R8
endmodule

// File: rtl/pwmb_ctrl.sv
module pwmb_ctrl
  import pwmb_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_BRK = 2,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PSC_W   = 16,
  parameter int unsigned FLT_W   = 4,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [DATA_W-1:0]            rdData,
  input  logic [NUM_BRK-1:0]           brkIn,
  input  logic                         updateEvt,
  input  logic [CNT_W-1:0]             countVal,
  output dpCtrlT                       dpCtrl,
  output logic [PSC_W-1:0]             pscVal,
  output logic [CNT_W-1:0]             periodVal,
  output logic [NUM_CH*CNT_W-1:0]      cmpFlat,
  output logic [NUM_CH*CH_CFG_W-1:0]   chCfg,
  output logic                         breakAny
);
  localparam int unsigned CFG_BITS = NUM_CH * CH_CFG_W;

  logic                cntRunR, preloadR, aoeR, moeR;
  logic [PSC_W-1:0]    pscR;
  logic [CNT_W-1:0]    periodR;
  logic [CNT_W-1:0]    cmpR [NUM_CH];
  logic [CFG_BITS-1:0] chCfgR;
  logic [NUM_BRK-1:0]  brkEnR, brkHighR, brkHit;
  logic [FLT_W-1:0]    brkFiltR [NUM_BRK];
  logic [DATA_W-1:0]   brkRead;
  logic                anyChEn, ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == A_CTRL);

  always_comb begin
    anyChEn = 1'b0;
    for (int k = 0; k < NUM_CH; k++) anyChEn |= chCfgR[k*CH_CFG_W + CFG_EN];
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntRunR  <= 1'b0;
      preloadR <= 1'b0;
      aoeR     <= 1'b0;
      pscR     <= '0;
      periodR  <= '1;
      chCfgR   <= '0;
      brkEnR   <= '0;
      brkHighR <= '0;
      for (int k = 0; k < NUM_CH; k++) cmpR[k] <= '0;
      for (int b = 0; b < NUM_BRK; b++) brkFiltR[b] <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_CTRL: begin
          cntRunR  <= wrData[CTL_RUN] | (cntRunR & anyChEn);
          preloadR <= wrData[CTL_PRE];
          aoeR     <= wrData[CTL_AOE];
        end
        A_PRESC:  pscR    <= wrData[PSC_W-1:0];
        A_PERIOD: periodR <= wrData[CNT_W-1:0];
        A_CHCFG:  chCfgR  <= wrData[CFG_BITS-1:0];
        A_BRKCFG: begin
          for (int b = 0; b < NUM_BRK; b++) begin
            brkEnR[b]   <= wrData[b*BRK_SLOT];
            brkHighR[b] <= wrData[b*BRK_SLOT + 1];
            brkFiltR[b] <= wrData[b*BRK_SLOT + 2 +: FLT_W];
          end
        end
        default: ;
      endcase
      for (int k = 0; k < NUM_CH; k++)
        if (wrAddr == ADDR_W'(int'(A_CMP0) + k)) cmpR[k] <= wrData[CNT_W-1:0];
    end
  end

  // main output enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 moeR <= 1'b0;
    else if (breakAny)         moeR <= 1'b0;
    else if (ctrlWr)           moeR <= wrData[CTL_MOE];
    else if (aoeR && updateEvt) moeR <= 1'b1;
  end

  // break qualification
  for (genvar b = 0; b < NUM_BRK; b++) begin : gBrk
    pwmb_brkfilt #(.FLT_W(FLT_W)) uFilt (
      .clk       (clk),
      .rstN      (rstN),
      .en        (brkEnR[b]),
      .activeHigh(brkHighR[b]),
      .filt      (brkFiltR[b]),
      .rawIn     (brkIn[b]),
      .hit       (brkHit[b])
    );
  end
  assign breakAny = |brkHit;

  // strobes and values toward the datapath
  assign dpCtrl.swUpdate  = wrEn && (wrAddr == A_UPDATE) && wrData[0];
  assign dpCtrl.cntRun    = cntRunR;
  assign dpCtrl.arPreload = preloadR;
  assign dpCtrl.outGate   = moeR & ~breakAny;
  assign pscVal    = pscR;
  assign periodVal = periodR;
  assign chCfg     = chCfgR;
  for (genvar k = 0; k < NUM_CH; k++) begin : gCmp
    assign cmpFlat[k*CNT_W +: CNT_W] = cmpR[k];
  end

  // readback
  always_comb begin
    brkRead = '0;
    for (int b = 0; b < NUM_BRK; b++)
      brkRead[b*BRK_SLOT +: BRK_SLOT] = BRK_SLOT'({brkFiltR[b], brkHighR[b], brkEnR[b]});
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL:   rdData[3:0]          = {moeR, aoeR, preloadR, cntRunR};
      A_PRESC:  rdData[PSC_W-1:0]    = pscR;
      A_PERIOD: rdData[CNT_W-1:0]    = periodR;
      A_CHCFG:  rdData[CFG_BITS-1:0] = chCfgR;
      A_BRKCFG: rdData               = brkRead;
      A_COUNT:  rdData[CNT_W-1:0]    = countVal;
      default: ;
    endcase
    for (int k = 0; k < NUM_CH; k++)
      if (rdAddr == ADDR_W'(int'(A_CMP0) + k)) rdData[CNT_W-1:0] = cmpR[k];
  end

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cntRunR) |-> $past(!anyChEn)); // R7
  AST_MOE_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    breakAny |=> !moeR); // R9
  AST_MOE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(moeR) |-> $past((ctrlWr && wrData[CTL_MOE]) || (aoeR && updateEvt))); // R10
endmodule

// File: rtl/pwmb_datapath.sv
module pwmb_datapath
  import pwmb_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrlT                     dpCtrl,
  input  logic [PSC_W-1:0]           pscVal,
  input  logic [CNT_W-1:0]           periodVal,
  input  logic [NUM_CH*CNT_W-1:0]    cmpFlat,
  input  logic [NUM_CH*CH_CFG_W-1:0] chCfg,
  output logic [NUM_CH-1:0]          pwmOut,
  output logic [NUM_CH-1:0]          pwmOutN,
  output logic [CNT_W-1:0]           countVal,
  output logic                       updateEvt
);
  logic [PSC_W-1:0] pscShadow, pscCnt;
  logic [CNT_W-1:0] perShadow, cnt, periodEff;
  logic [CNT_W-1:0] cmpShadow [NUM_CH];
  logic             tick, wrapEvt;

  assign periodEff = dpCtrl.arPreload ? perShadow : periodVal;
  assign tick      = dpCtrl.cntRun && (pscCnt >= pscShadow);
  assign wrapEvt   = tick && (cnt >= periodEff);
  assign updateEvt = wrapEvt | dpCtrl.swUpdate;
  assign countVal  = cnt;

  // prescaler and counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
      cnt    <= '0;
    end else if (dpCtrl.swUpdate) begin
      pscCnt <= '0;
      cnt    <= '0;
    end else if (dpCtrl.cntRun) begin
      if (tick) begin
        pscCnt <= '0;
        cnt    <= wrapEvt ? '0 : cnt + CNT_W'(1);
      end else begin
        pscCnt <= pscCnt + PSC_W'(1);
      end
    end
  end

  // shadow registers, loaded on every update event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscShadow <= '0;
      perShadow <= '1;
      for (int k = 0; k < NUM_CH; k++) cmpShadow[k] <= '0;
    end else if (updateEvt) begin
      pscShadow <= pscVal;
      perShadow <= periodVal;
      for (int k = 0; k < NUM_CH; k++) cmpShadow[k] <= cmpFlat[k*CNT_W +: CNT_W];
    end
  end

  // per-channel output stage
  for (genvar k = 0; k < NUM_CH; k++) begin : gCh
    logic refAct;
    assign refAct = cnt < cmpShadow[k];
    assign pwmOut[k]  = (dpCtrl.outGate & chCfg[k*CH_CFG_W + CFG_EN] & refAct)
                        ^ chCfg[k*CH_CFG_W + CFG_POL];
    assign pwmOutN[k] = (dpCtrl.outGate & chCfg[k*CH_CFG_W + CFG_NEN] & ~refAct)
                        ^ chCfg[k*CH_CFG_W + CFG_NPOL];
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0))); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtrl.cntRun && !dpCtrl.swUpdate) |=> $stable(cnt)); // R2
endmodule

// File: rtl/pwmb_top.sv
module pwmb_top
  import pwmb_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_BRK = 2,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PSC_W   = 16,
  parameter int unsigned FLT_W   = 4,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [3:0]          wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [3:0]          rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_BRK-1:0]  brkIn,
  output logic [NUM_CH-1:0]   pwmOut,
  output logic [NUM_CH-1:0]   pwmOutN
);
  dpCtrlT                     dpCtrl;
  logic [PSC_W-1:0]           pscVal;
  logic [CNT_W-1:0]           periodVal, countVal;
  logic [NUM_CH*CNT_W-1:0]    cmpFlat;
  logic [NUM_CH*CH_CFG_W-1:0] chCfg;
  logic                       updateEvt, breakAny;
  logic [NUM_CH-1:0]          polVec, nPolVec;

  pwmb_ctrl #(
    .NUM_CH(NUM_CH), .NUM_BRK(NUM_BRK), .CNT_W(CNT_W),
    .PSC_W(PSC_W), .FLT_W(FLT_W), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .brkIn(brkIn), .updateEvt(updateEvt),
    .countVal(countVal), .dpCtrl(dpCtrl), .pscVal(pscVal), .periodVal(periodVal),
    .cmpFlat(cmpFlat), .chCfg(chCfg), .breakAny(breakAny)
  );

  pwmb_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PSC_W(PSC_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .pscVal(pscVal), .periodVal(periodVal),
    .cmpFlat(cmpFlat), .chCfg(chCfg), .pwmOut(pwmOut), .pwmOutN(pwmOutN),
    .countVal(countVal), .updateEvt(updateEvt)
  );

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      polVec[k]  = chCfg[k*CH_CFG_W + CFG_POL];
      nPolVec[k] = chCfg[k*CH_CFG_W + CFG_NPOL];
    end
  end

  AST_BREAK_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    breakAny |-> (pwmOut == polVec && pwmOutN == nPolVec)); // R9
endmodule

// File: tb/tb_pwmb_top.sv
module tb_pwmb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [1:0]  brkIn = 2'b10;
  logic [3:0]  pwmOut, pwmOutN;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwmb_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .brkIn(brkIn), .pwmOut(pwmOut), .pwmOutN(pwmOutN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output int v);
    rdAddr = a; #1; v = int'(rdData);
  endtask

  task automatic highCount(input int k, input bit useN, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      c += useN ? int'(pwmOutN[k]) : int'(pwmOut[k]);
    end
  endtask

  task automatic maxCount(input int n, output int m);
    int v;
    m = 0;
    repeat (n) begin
      @(negedge clk);
      regRead(4'd10, v);
      if (v > m) m = v;
    end
  endtask

  task automatic moeBit(output int v);
    int r;
    regRead(4'd0, r);
    v = (r >> 3) & 1;
  endtask

  task automatic t_reset;
    int v;
    regRead(4'd0, v);  chk("R1 control reset", v, 0);
    regRead(4'd3, v);  chk("R1 period reset", v, 16'hFFFF);
    regRead(4'd4, v);  chk("R1 channel cfg reset", v, 0);
    chk("R1 pins low", int'({pwmOut, pwmOutN}), 0);
    idle(3);
    regRead(4'd10, v); chk("R1 counter stopped", v, 0);
  endtask

  task automatic t_duty;
    int c, v;
    regWrite(4'd3, 16'd9);
    regWrite(4'd2, 16'd0);
    regWrite(4'd5, 16'd3);
    regWrite(4'd6, 16'd0);
    regWrite(4'd7, 16'd12);
    regWrite(4'd4, 16'h0111);
    regWrite(4'd0, 16'h0009);
    regWrite(4'd1, 16'd1);
    regRead(4'd10, v); chk("R6 count zero after update", v, 0);
    highCount(0, 0, 10, c); chk("R3 duty cmp=3", c, 3);
    highCount(1, 0, 10, c); chk("R3 cmp zero never active", c, 0);
    highCount(2, 0, 10, c); chk("R3 cmp above period always active", c, 10);
    regWrite(4'd5, 16'd7);
    regWrite(4'd1, 16'd1);
    highCount(0, 0, 10, c); chk("R6 compare loaded by update", c, 7);
  endtask

  task automatic t_prescale;
    int c;
    regWrite(4'd2, 16'd1);
    regWrite(4'd1, 16'd1);
    highCount(0, 0, 20, c); chk("R2 prescaler divide by two", c, 14);
    regWrite(4'd2, 16'd0);
    regWrite(4'd1, 16'd1);
  endtask

  task automatic t_polarity;
    int c;
    regWrite(4'd5, 16'd3);
    regWrite(4'd6, 16'd3);
    regWrite(4'd8, 16'd3);
    regWrite(4'd4, 16'hD253);
    regWrite(4'd1, 16'd1);
    highCount(0, 0, 10, c); chk("R4 inverted main", c, 7);
    highCount(1, 1, 10, c); chk("R4 complementary", c, 7);
    highCount(1, 0, 10, c); chk("R4 main beside complementary", c, 3);
    highCount(2, 0, 10, c); chk("R4 disabled holds polarity", c, 10);
    highCount(3, 1, 10, c); chk("R4 inverted complementary", c, 3);
  endtask

  task automatic t_preload;
    int m;
    regWrite(4'd0, 16'h000B);
    regWrite(4'd3, 16'd9);
    regWrite(4'd1, 16'd1);
    regWrite(4'd3, 16'd4);
    maxCount(12, m); chk("R5 buffered period waits", m, 9);
    maxCount(12, m); chk("R5 buffered period after update", m, 4);
    regWrite(4'd0, 16'h0009);
    regWrite(4'd3, 16'd9);
    regWrite(4'd1, 16'd1);
    regWrite(4'd3, 16'd4);
    maxCount(12, m); chk("R5 unbuffered period immediate", m, 4);
    regWrite(4'd3, 16'd9);
    regWrite(4'd1, 16'd1);
  endtask

  task automatic t_runhold;
    int v, a, b;
    regWrite(4'd0, 16'h0008);
    regRead(4'd0, v); chk("R7 run kept while channel enabled", v & 1, 1);
    regWrite(4'd4, 16'h0000);
    regWrite(4'd0, 16'h0008);
    regRead(4'd0, v); chk("R7 run cleared when all disabled", v & 1, 0);
    regRead(4'd10, a);
    idle(3);
    regRead(4'd10, b); chk("R7 counter frozen", b, a);
    regWrite(4'd4, 16'h000D);
    regWrite(4'd0, 16'h0009);
    regWrite(4'd1, 16'd1);
  endtask

  task automatic t_breakFilter;
    int c, v;
    regWrite(4'd9, 16'h000B);
    brkIn[0] = 1'b1;
    idle(2);
    brkIn[0] = 1'b0;
    idle(4);
    moeBit(v); chk("R8 short pulse ignored", v, 1);
    highCount(0, 0, 10, c); chk("R8 output unaffected by short pulse", c, 3);
    brkIn[0] = 1'b1;
    idle(2);
    moeBit(v); chk("R8 not yet qualified", v, 1);
    idle(1);
    chk("R9 main pin forced same cycle", int'(pwmOut[0]), 0);
    chk("R9 complementary forced same cycle", int'(pwmOutN[0]), 1);
    idle(1);
    moeBit(v); chk("R9 main enable cleared", v, 0);
    highCount(0, 0, 10, c); chk("R9 main inactive during break", c, 0);
    highCount(0, 1, 10, c); chk("R9 complementary inactive during break", c, 10);
    regWrite(4'd0, 16'h0009);
    moeBit(v); chk("R9 set ignored during break", v, 0);
  endtask

  task automatic t_noRearm;
    int c, v;
    brkIn[0] = 1'b0;
    idle(15);
    moeBit(v); chk("R10 stays clear without re-arm", v, 0);
    highCount(0, 0, 10, c); chk("R10 pins gated while clear", c, 0);
    regWrite(4'd0, 16'h0009);
    moeBit(v); chk("R10 set by write", v, 1);
    highCount(0, 0, 10, c); chk("R10 outputs return", c, 3);
  endtask

  task automatic t_rearm;
    int c, v;
    regWrite(4'd0, 16'h000D);
    regWrite(4'd9, 16'h0100);
    brkIn[1] = 1'b0;
    idle(1);
    brkIn[1] = 1'b1;
    chk("R9 active-low break forces main", int'(pwmOut[0]), 0);
    chk("R9 active-low break forces complementary", int'(pwmOutN[0]), 1);
    idle(1);
    moeBit(v); chk("R9 cleared by second break", v, 0);
    idle(12);
    moeBit(v); chk("R10 re-armed at update", v, 1);
    highCount(0, 0, 10, c); chk("R10 duty after re-arm", c, 3);
  endtask

  task automatic t_breakDisabled;
    int c, v;
    regWrite(4'd9, 16'h0000);
    brkIn = 2'b01;
    idle(8);
    moeBit(v); chk("R8 disabled break ignored", v, 1);
    highCount(0, 0, 10, c); chk("R8 pins unaffected by disabled break", c, 3);
    brkIn = 2'b10;
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_duty();
    t_prescale();
    t_polarity();
    t_preload();
    t_runhold();
    t_breakFilter();
    t_noRearm();
    t_rearm();
    t_breakDisabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule